// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block reads one 16-bit word from a three-wire serial EEPROM. It drives chip select, serial clock and a data line towards the memory, and samples a data line coming back. A host pulses `req_i` with a 6-bit word address. The block then runs a fixed pin sequence with no further input from the host. First a flush clocks the memory out of any half-finished transfer. Then it sends an 11-bit read command and clocks in 16 data bits, most significant first. A second flush follows. At the end the block pulses `done_o` and presents the word on `data_o`.

Every pin change opens a phase, and each phase lasts exactly `DELAY_CYC` system clock cycles (minimum 1). This one parameter sets the serial clock half-period and the setup and hold margins. At 100 MHz, the default of 30 cycles keeps every pin change at least 300 ns apart. The package also holds the opcodes of the memory's other commands (write 0x140, erase 0x1C0, write enable 0x130, write disable 0x100, erase all 0x120, write all 0x110) and the 6-bit address mask. Only the read command is issued.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, `ee_cs_o`, `ee_sk_o`, `ee_di_o`, `busy_o` and `done_o` are low and `data_o` is zero.
- R2: A request while idle is accepted. `busy_o` is high from the next cycle until the cycle in which `done_o` pulses, and it is low in that cycle.
- R3: Each pin state (phase) holds for exactly `DELAY_CYC` clock cycles. A read therefore lasts 193 phases with the default `FLUSH_PULSES` of 25.
- R4: The leading flush has 55 phases, written here as (cs,sk): (1,0), (1,1), then `FLUSH_PULSES` pairs of (1,0),(1,1), then (1,0), (0,0), and finally all three lines low.
- R5: After the leading flush come one phase with all lines low and then one phase with chip select high and clock low.
- R6: The command word is 0x180 OR (address AND 0x3F). It is sent as 11 bits from bit 10 down to bit 0. Each bit takes three phases with chip select high: data set with clock low, clock high, clock low.
- R7: Each of the 16 data bits takes three phases: clock high, clock high, clock low. `ee_do_i` is sampled at the end of the first of these phases, and the bits fill `data_o` most significant first.
- R8: The trailing flush repeats the R4 pattern. The data line keeps the last command bit until the final phase, in which all lines go low.
- R9: `done_o` is high for exactly one cycle, right after the last phase. `data_o` then holds the word read and keeps it until the next read's data phases.
- R10: A request while `busy_o` is high is ignored. The pin sequence and the word returned are those of the accepted request, and no second read starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, accepted only while idle |
| addr_i | input | 6 | Word address of the read |
| busy_o | output | 1 | High while a read is in progress |
| done_o | output | 1 | One-cycle pulse when the word is ready |
| data_o | output | 16 | Word read from the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data towards the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
The bench builds the block with `DELAY_CYC` = 2 and the default 25 flush pulses. With two cycles per phase, an off-by-one in the phase timer moves a pin edge by one cycle, and the bench sees this because it compares every cycle against the expected phase list. It also sees a sample point moved by one cycle, through the data returned. Each read takes 386 cycles. This leaves room to read the lowest and highest addresses and two alternating-bit addresses from a behavioural EEPROM model, and to put an ignored request in the middle of a read.

// File: rtl/eerd_pkg.sv
`timescale 1ns/1ps
package eerd_pkg;
  localparam int CMD_W = 11;

  localparam logic [CMD_W-1:0] OPC_READ      = 11'h180;
  localparam logic [CMD_W-1:0] OPC_WRITE     = 11'h140;
  localparam logic [CMD_W-1:0] OPC_ERASE     = 11'h1C0;
  localparam logic [CMD_W-1:0] OPC_WR_EN     = 11'h130;
  localparam logic [CMD_W-1:0] OPC_WR_DIS    = 11'h100;
  localparam logic [CMD_W-1:0] OPC_ERASE_ALL = 11'h120;
  localparam logic [CMD_W-1:0] OPC_WRITE_ALL = 11'h110;
  localparam logic [CMD_W-1:0] ADDR_MASK     = 11'h03F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_PREP,
    ST_CMD,
    ST_DATA
  } rd_state_e;
endpackage

// File: rtl/eerd_pacer.sv
`timescale 1ns/1ps
module eerd_pacer #(
  parameter int DELAY_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic step_o
);
  localparam int CNT_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(DELAY_CYC));
endmodule

// File: rtl/eerd_piso.sv
`timescale 1ns/1ps
module eerd_piso #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         ser_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign ser_o = sr_q[W-1];
endmodule

// File: rtl/eerd_sipo.sv
`timescale 1ns/1ps
module eerd_sipo #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      par_o <= '0;
    else if (shift_i) par_o <= {par_o[W-2:0], ser_i};
  end
endmodule

// File: rtl/eeprom_word_reader.sv
`timescale 1ns/1ps
module eeprom_word_reader
  import eerd_pkg::*;
#(
  parameter int DELAY_CYC    = 30,
  parameter int FLUSH_PULSES = 25,
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  localparam int FLUSH_LAST = 2 * FLUSH_PULSES + 4;
  localparam int SK_LAST    = 2 * FLUSH_PULSES + 1;
  localparam int SUB_W      = $clog2(FLUSH_LAST + 1);
  localparam int BIT_W      = $clog2(DATA_W > CMD_W ? DATA_W : CMD_W);
  localparam logic [SUB_W-1:0] SUB_END  = SUB_W'(FLUSH_LAST);
  localparam logic [SUB_W-1:0] SUB_SK   = SUB_W'(SK_LAST);
  localparam logic [SUB_W-1:0] SUB_CS   = SUB_W'(SK_LAST + 1);
  localparam logic [BIT_W-1:0] CMD_TOP  = BIT_W'(CMD_W - 1);
  localparam logic [BIT_W-1:0] DATA_TOP = BIT_W'(DATA_W - 1);

  rd_state_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [BIT_W-1:0] bit_q;
  logic             tail_q;
  logic             cs_q, sk_q, di_q, done_q;
  logic             step, accept;
  logic             cmd_shift, cmd_msb, dat_shift;
  logic [CMD_W-1:0] cmd_word;

  assign accept    = (state_q == ST_IDLE) && req_i;
  assign cmd_word  = OPC_READ | (CMD_W'(addr_i) & ADDR_MASK);
  assign cmd_shift = step && (((state_q == ST_PREP) && (sub_q != '0)) ||
                              ((state_q == ST_CMD) && (sub_q == SUB_W'(2)) && (bit_q != '0)));
  assign dat_shift = step && (state_q == ST_DATA) && (sub_q == '0);

  eerd_pacer #(.DELAY_CYC(DELAY_CYC)) i_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .run_i   (state_q != ST_IDLE),
    .step_o  (step)
  );

  eerd_piso #(.W(CMD_W)) i_cmd_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (cmd_word),
    .shift_i    (cmd_shift),
    .ser_o      (cmd_msb)
  );

  eerd_sipo #(.W(DATA_W)) i_data_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (dat_shift),
    .ser_i   (ee_do_i),
    .par_o   (data_o)
  );

  // every pin update marks the start of a new phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      tail_q  <= 1'b0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_FLUSH;
          sub_q   <= '0;
          tail_q  <= 1'b0;
          cs_q    <= 1'b1;
          sk_q    <= 1'b0;
          di_q    <= 1'b0;
        end
        ST_FLUSH: if (step) begin
          if (sub_q == SUB_END) begin
            sub_q <= '0;
            if (tail_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_PREP;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
            if (sub_q < SUB_SK)       sk_q <= ~sub_q[0];
            else if (sub_q == SUB_SK) sk_q <= 1'b0;
            else if (sub_q == SUB_CS) cs_q <= 1'b0;
            else                      di_q <= 1'b0;
          end
        end
        ST_PREP: if (step) begin
          if (sub_q == '0) begin
            sub_q <= SUB_W'(1);
            cs_q  <= 1'b1;
          end else begin
            state_q <= ST_CMD;
            sub_q   <= '0;
            bit_q   <= CMD_TOP;
            di_q    <= cmd_msb;
          end
        end
        ST_CMD: if (step) begin
          if (sub_q == '0) begin
            sub_q <= SUB_W'(1);
            sk_q  <= 1'b1;
          end else if (sub_q == SUB_W'(1)) begin
            sub_q <= SUB_W'(2);
            sk_q  <= 1'b0;
          end else if (bit_q == '0) begin
            state_q <= ST_DATA;
            sub_q   <= '0;
            bit_q   <= DATA_TOP;
            sk_q    <= 1'b1;
          end else begin
            sub_q <= '0;
            bit_q <= bit_q - 1'b1;
            di_q  <= cmd_msb;
          end
        end
        ST_DATA: if (step) begin
          if (sub_q == '0) begin
            sub_q <= SUB_W'(1);
          end else if (sub_q == SUB_W'(1)) begin
            sub_q <= SUB_W'(2);
            sk_q  <= 1'b0;
          end else if (bit_q == '0) begin
            state_q <= ST_FLUSH;
            sub_q   <= '0;
            tail_q  <= 1'b1;
            cs_q    <= 1'b1;
            sk_q    <= 1'b0;
          end else begin
            sub_q <= '0;
            bit_q <= bit_q - 1'b1;
            sk_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign ee_cs_o = cs_q;
  assign ee_sk_o = sk_q;
  assign ee_di_o = di_q;

  assert_done_not_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_phase_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !step) |=> $stable({cs_q, sk_q, di_q}));
  assert_sk_needs_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_q |-> cs_q);
  assert_idle_lines_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(cs_q || sk_q || di_q));
  assert_busy_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !step) |=> busy_o);
endmodule

// File: tb/test_eeprom_word_reader.sv
`timescale 1ns/1ps
module test_eeprom_word_reader;
  localparam int DLY = 2;
  localparam int NP  = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [5:0]  addr = '0;
  logic        busy, done, cs, sk, di;
  logic        dout = 1'b0;
  logic [15:0] data;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  eeprom_word_reader #(.DELAY_CYC(DLY), .FLUSH_PULSES(NP)) i_eeprom_word_reader (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .addr_i  (addr),
    .busy_o  (busy),
    .done_o  (done),
    .data_o  (data),
    .ee_cs_o (cs),
    .ee_sk_o (sk),
    .ee_di_o (di),
    .ee_do_i (dout)
  );

  function automatic logic [15:0] word_at(input logic [5:0] a);
    return 16'((int'(a) + 1) * 40503) ^ 16'h5AC3;
  endfunction

  // behavioural serial EEPROM: looks for a start bit, takes opcode+address, shifts out data
  int          dev_st = 0;
  int          dev_n = 0;
  logic [7:0]  dev_cmd = '0;
  logic [15:0] dev_word = '0;

  always @(posedge cs) begin dev_st = 0; dev_n = 0; end
  always @(negedge cs) begin dev_st = 0; dout = 1'b0; end
  always @(posedge sk) if (cs) begin
    case (dev_st)
      0: if (di) begin dev_st = 1; dev_n = 0; end
      1: begin
        dev_cmd = {dev_cmd[6:0], di};
        dev_n++;
        if (dev_n == 8) begin
          dev_st = 2; dev_n = 0;
          dev_word = (dev_cmd[7:6] == 2'b10) ? word_at(dev_cmd[5:0]) : 16'hFFFF;
        end
      end
      2: begin
        dout = dev_word[15 - dev_n];
        dev_n++;
        if (dev_n == 16) dev_st = 3;
      end
      default: ;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [2:0] exp_q[$];
  string      tag_q[$];

  task automatic push_ph(input logic c, input logic s, input logic d, input string t);
    exp_q.push_back({c, s, d});
    tag_q.push_back(t);
  endtask

  task automatic push_flush(input logic d, input string t);
    push_ph(1, 0, d, t);
    push_ph(1, 1, d, t);
    for (int i = 0; i < NP; i++) begin
      push_ph(1, 0, d, t);
      push_ph(1, 1, d, t);
    end
    push_ph(1, 0, d, t);
    push_ph(0, 0, d, t);
    push_ph(0, 0, 0, t);
  endtask

  task automatic run_read(input logic [5:0] a, input int poke_at, input logic [5:0] poke_addr);
    logic [10:0] cw;
    int idx;
    cw = 11'h180 | {5'd0, a};
    exp_q.delete();
    tag_q.delete();
    push_flush(1'b0, "R4 lead flush");
    push_ph(0, 0, 0, "R5 gap");
    push_ph(1, 0, 0, "R5 select");
    for (int b = 10; b >= 0; b--) begin
      push_ph(1, 0, cw[b], "R6 cmd");
      push_ph(1, 1, cw[b], "R6 cmd");
      push_ph(1, 0, cw[b], "R6 cmd");
    end
    for (int b = 0; b < 16; b++) begin
      push_ph(1, 1, cw[0], "R7 data");
      push_ph(1, 1, cw[0], "R7 data");
      push_ph(1, 0, cw[0], "R7 data");
    end
    push_flush(cw[0], "R8 tail flush");
    chk(exp_q.size() == 193, "R3 phase count", 32'(exp_q.size()), 32'd193);

    @(negedge clk);
    req = 1'b1;
    addr = a;
    @(negedge clk);
    req = 1'b0;
    idx = 0;
    foreach (exp_q[p]) begin
      for (int c = 0; c < DLY; c++) begin
        chk({cs, sk, di} === exp_q[p], $sformatf("%s R3 ph%0d c%0d", tag_q[p], p, c),
            32'({cs, sk, di}), 32'(exp_q[p]));
        chk(busy === 1'b1 && done === 1'b0, "R2 busy during read", 32'({busy, done}), 32'b10);
        if (idx == poke_at) begin
          req = 1'b1;
          addr = poke_addr;
        end else begin
          req = 1'b0;
        end
        idx++;
        @(negedge clk);
      end
    end
    req = 1'b0;
    chk(done === 1'b1, "R9 done pulse", 32'(done), 32'd1);
    chk(busy === 1'b0, "R2 busy low with done", 32'(busy), 32'd0);
    chk(data === word_at(a), "R7 R9 word returned", 32'(data), 32'(word_at(a)));
    chk({cs, sk, di} === 3'b000, "R8 lines cleared", 32'({cs, sk, di}), 32'd0);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", 32'(done), 32'd0);
    chk(data === word_at(a), "R9 word held", 32'(data), 32'(word_at(a)));
    chk(busy === 1'b0, "R10 no second read", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cs, sk, di} === 3'b000, "R1 lines in reset", 32'({cs, sk, di}), 32'd0);
    chk(busy === 1'b0 && done === 1'b0, "R1 status in reset", 32'({busy, done}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(data === 16'h0000, "R1 data after reset", 32'(data), 32'd0);
    chk(busy === 1'b0, "R1 idle after reset", 32'(busy), 32'd0);

    run_read(6'd0, -1, 6'd0);
    run_read(6'd63, -1, 6'd0);
    run_read(6'h2A, 100, 6'h15);   // R10: request mid-read
    run_read(6'h15, 380, 6'h3F);   // R10: request near the end
    repeat (5) @(negedge clk);
    chk(busy === 1'b0 && {cs, sk, di} === 3'b000, "R10 stays idle", 32'({busy, cs, sk, di}), 32'd0);
    chk(data === word_at(6'h15), "R9 word kept while idle", 32'(data), 32'(word_at(6'h15)));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule